// File: doc/BRIEF.md
# Rectangular frame-buffer transfer engine

This block copies rectangles of 16-bit pixels between a 32-bit word stream and a frame memory organised as 512 rows of 1024 pixels. An image transfer is opened by a three-word header: an opcode word, a placement word and an extent word. A write opcode turns the words that follow into pixel data for memory. A read opcode makes the block fetch the rectangle and present it on a separate output stream. Each stream word holds two pixels, and the first pixel in stream order sits in the low half.

Pixels are walked one at a time, left to right and then downward. Columns and rows wrap around the memory edges. A word can hold the last pixel of one row and the first pixel of the next. Gaps in the input stream and stalls on the output stream only suspend the walk; the position inside the row is kept. The block raises a flag while a read is open. When a write completes, it reports the rectangle it covered, so that caches built from that memory can be refreshed. Words outside a transfer that carry another opcode belong to a different engine, and this block drops them.

Top module: `rect_xfer_engine`

## Requirements
- R1: After reset, busy, img_ready, out_valid, dirty_valid and mem_en are all 0, and in_ready is 1 once the block is idle.
- R2: Outside a transfer, a word whose bits 31:24 equal 0xA0 opens a write and a word whose bits 31:24 equal 0xC0 opens a read. The next two accepted words are the placement word and the extent word. Any other word is accepted and dropped: busy stays 0 and memory is not accessed.
- R3: The placement word gives the left column in bits 9:0 and the top row in bits 24:16. The extent word gives the width in bits 9:0 and the height in bits 24:16. A width field of 0 stands for 1024 and a height field of 0 stands for 512.
- R4: Pixel k of a W-wide rectangle at column X, row Y goes to memory address ((Y + k/W) mod 512)·1024 + ((X + k mod W) mod 1024). Pixels are taken row by row, and bits 15:0 of a stream word come before bits 31:16.
- R5: A word may span the end of one row and the start of the next. When the pixel count is odd, the high half of the final write word is discarded and the high half of the final read word is 0. A transfer of N pixels makes exactly N memory writes, for a write, or produces ceil(N/2) output words, for a read.
- R6: Idle cycles between input words at any point in a write, including mid-row, do not change which pixel goes to which address.
- R7: img_ready rises in the cycle after the extent word of a read is accepted. It falls, together with busy, once the last output word of that read has been accepted.
- R8: While out_valid is 1 and out_ready is 0, out_data holds its value and no pixel is lost or repeated, whatever the pattern of out_ready.
- R9: When the last pixel of a write is stored, dirty_valid is 1 for one cycle, with dirty_x, dirty_y, dirty_w and dirty_h holding the start column, start row, width and height of that write.
- R10: An 0xA0 or 0xC0 word arriving while a read is open ends that read at once: img_ready and out_valid go to 0, any staged output word is dropped, and the new header proceeds normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Input stream word valid |
| in_ready | output | 1 | Input stream word accepted when both are high |
| in_data | input | 32 | Input stream word: opcode, header or pixel pair |
| out_valid | output | 1 | Read-out word valid |
| out_ready | input | 1 | Read-out sink accepts the word |
| out_data | output | 32 | Read-out pixel pair, first pixel in bits 15:0 |
| mem_en | output | 1 | Frame memory access this cycle |
| mem_we | output | 1 | Access is a write (otherwise a read) |
| mem_addr | output | 19 | Pixel address, row in bits 18:10, column in bits 9:0 |
| mem_wdata | output | 16 | Pixel to store |
| mem_rdata | input | 16 | Pixel read, valid one cycle after a read access |
| busy | output | 1 | A header or transfer is in progress |
| img_ready | output | 1 | A read transfer is open |
| dirty_valid | output | 1 | One-cycle pulse: a write has finished |
| dirty_x | output | 10 | Start column of the finished write |
| dirty_y | output | 9 | Start row of the finished write |
| dirty_w | output | 11 | Width of the finished write, 1 to 1024 |
| dirty_h | output | 10 | Height of the finished write, 1 to 512 |

## Verification
The hardest case to reach from the ports is a read cut off by a new write opcode while a finished output word sits unaccepted. The bench holds out_ready low until a word has been staged, and only then sends the write opcode. It checks that the staged word is gone and that the write that follows lands intact. Odd-width rectangles placed at column 1022, row 511 push pixel pairs across row ends while both address wraps occur. The zero width and zero height fields produce 1024-wide and 512-tall shapes. Random gaps on the input and random out_ready on the output run through the rest of the transfers.

// File: rtl/rxe_pkg.sv
package rxe_pkg;
  // opcodes in the top byte of a stream word that open an image transfer
  localparam logic [7:0] OPC_STORE = 8'hA0;
  localparam logic [7:0] OPC_FETCH = 8'hC0;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PLACE,
    ST_EXTENT,
    ST_STORE,
    ST_FETCH
  } eng_state_t;
endpackage

// File: rtl/rxe_extent.sv
// Turns a raw extent field into a span where an all-zero field means full size.
module rxe_extent #(
  parameter int BITS = 10
) (
  input  logic [BITS-1:0] field,
  output logic [BITS:0]   span
);
  assign span = (field == '0) ? {1'b1, {BITS{1'b0}}} : {1'b0, field};
endmodule

// File: rtl/rxe_walker.sv
// Walks a rectangle one pixel per step, keeping the column offset inside the
// current row so that a walk can stop and resume anywhere.
module rxe_walker #(
  parameter int X_BITS = 10,
  parameter int Y_BITS = 9,
  localparam int AW = X_BITS + Y_BITS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [X_BITS-1:0] ld_x,
  input  logic [Y_BITS-1:0] ld_y,
  input  logic [X_BITS:0]   ld_w,
  input  logic [Y_BITS:0]   ld_h,
  input  logic              step,
  output logic [AW-1:0]     addr,
  output logic              active,
  output logic              last
);
  logic [X_BITS-1:0] x0_q, col_q, col_n, col_abs;
  logic [X_BITS:0]   w_q, col_nx;
  logic [Y_BITS-1:0] row_q, row_n;
  logic [Y_BITS:0]   left_q, left_n;
  logic              row_end, cnt_en;

  assign col_abs = x0_q + col_q;
  assign addr    = {row_q, col_abs};
  assign active  = (left_q != '0);
  assign col_nx  = {1'b0, col_q} + {{X_BITS{1'b0}}, 1'b1};
  assign row_end = (col_nx == w_q);
  assign last    = active && row_end && (left_q == {{Y_BITS{1'b0}}, 1'b1});
  assign cnt_en  = load || (step && active);

  always_comb begin
    col_n  = col_q;
    row_n  = row_q;
    left_n = left_q;
    if (load) begin
      col_n  = '0;
      row_n  = ld_y;
      left_n = ld_h;
    end else if (step && active) begin
      if (row_end) begin
        col_n  = '0;
        row_n  = row_q + {{(Y_BITS-1){1'b0}}, 1'b1};
        left_n = left_q - {{Y_BITS{1'b0}}, 1'b1};
      end else begin
        col_n = col_nx[X_BITS-1:0];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      col_q  <= '0;
      row_q  <= '0;
      left_q <= '0;
    end else if (cnt_en) begin
      col_q  <= col_n;
      row_q  <= row_n;
      left_q <= left_n;
    end
  end

  // rectangle origin and width: data registers, loaded only with a header
  always_ff @(posedge clk) begin
    if (load) begin
      x0_q <= ld_x;
      w_q  <= ld_w;
    end
  end

  // R4: the column offset always stays inside the rectangle width
  a_r4_col_in_span: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> ({1'b0, col_q} < w_q));

  // R5: a row ends exactly when the rows-left count steps down by one
  a_r5_row_count: assert property (@(posedge clk) disable iff (!rst_n)
    (step && active && !load && row_end) |=> (left_q == $past(left_q) - 1'b1));
endmodule

// File: rtl/rect_xfer_engine.sv
module rect_xfer_engine
  import rxe_pkg::*;
#(
  parameter int X_BITS = 10,
  parameter int Y_BITS = 9,
  parameter int PIX_W  = 16,
  localparam int WORD_W = 2 * PIX_W,
  localparam int AW     = X_BITS + Y_BITS,
  localparam int V_LSB  = PIX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [WORD_W-1:0] in_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [WORD_W-1:0] out_data,
  output logic              mem_en,
  output logic              mem_we,
  output logic [AW-1:0]     mem_addr,
  output logic [PIX_W-1:0]  mem_wdata,
  input  logic [PIX_W-1:0]  mem_rdata,
  output logic              busy,
  output logic              img_ready,
  output logic              dirty_valid,
  output logic [X_BITS-1:0] dirty_x,
  output logic [Y_BITS-1:0] dirty_y,
  output logic [X_BITS:0]   dirty_w,
  output logic [Y_BITS:0]   dirty_h
);
  // ---------------------------------------------------------------- reset
  logic rst_meta, rst_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_q    <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_q    <= rst_meta;
    end
  end

  // ---------------------------------------------------------------- state
  eng_state_t        st_q, st_n;
  logic              fetch_q, fetch_n;     // open header is a read
  logic [1:0]        halves_q, halves_n;   // pixels left in the write buffer
  logic              img_q, img_n;
  logic              pend_q, pend_n;       // memory read in flight
  logic              plast_q, plast_n;     // in-flight read is the final pixel
  logic              havelo_q, havelo_n;   // low half of output word captured
  logic              oval_q, oval_n;
  logic              dv_q, dv_n;

  logic [X_BITS-1:0] x_q;
  logic [Y_BITS-1:0] y_q;
  logic [WORD_W-1:0] wbuf_q, wbuf_n;
  logic [PIX_W-1:0]  lo_q;
  logic [WORD_W-1:0] out_q, out_n;
  logic [X_BITS-1:0] dx_q;
  logic [Y_BITS-1:0] dy_q;
  logic [X_BITS:0]   dw_q;
  logic [Y_BITS:0]   dh_q;

  // ---------------------------------------------------------------- decode
  logic [7:0]        opc;
  logic              is_store_op, is_fetch_op, is_img_op;
  logic              in_fire, out_fire;
  logic              hdr_done, rd_abort, wr_pix, rd_issue;
  logic [X_BITS:0]   span_w;
  logic [Y_BITS:0]   span_h;
  logic [AW-1:0]     w_addr;
  logic              w_active, w_last;

  assign opc         = in_data[WORD_W-1 -: 8];
  assign is_store_op = (opc == OPC_STORE);
  assign is_fetch_op = (opc == OPC_FETCH);
  assign is_img_op   = is_store_op || is_fetch_op;

  assign in_ready = (st_q == ST_STORE) ? (halves_q == 2'd0) : 1'b1;
  assign in_fire  = in_valid && in_ready;
  assign out_fire = oval_q && out_ready;

  assign hdr_done = (st_q == ST_EXTENT) && in_fire;
  assign rd_abort = (st_q == ST_FETCH) && in_fire && is_img_op;
  assign wr_pix   = (st_q == ST_STORE) && (halves_q != 2'd0);
  assign rd_issue = (st_q == ST_FETCH) && !rd_abort && !pend_q && !oval_q && w_active;

  rxe_extent #(.BITS(X_BITS)) u_span_w (
    .field (in_data[X_BITS-1:0]),
    .span  (span_w)
  );

  rxe_extent #(.BITS(Y_BITS)) u_span_h (
    .field (in_data[V_LSB +: Y_BITS]),
    .span  (span_h)
  );

  rxe_walker #(.X_BITS(X_BITS), .Y_BITS(Y_BITS)) u_walk (
    .clk    (clk),
    .rst_n  (rst_q),
    .load   (hdr_done),
    .ld_x   (x_q),
    .ld_y   (y_q),
    .ld_w   (span_w),
    .ld_h   (span_h),
    .step   (wr_pix || rd_issue),
    .addr   (w_addr),
    .active (w_active),
    .last   (w_last)
  );

  // ---------------------------------------------------------------- next state
  always_comb begin
    st_n     = st_q;
    fetch_n  = fetch_q;
    halves_n = halves_q;
    img_n    = img_q;
    pend_n   = pend_q;
    plast_n  = plast_q;
    havelo_n = havelo_q;
    oval_n   = oval_q;
    dv_n     = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (in_fire && is_img_op) begin
          st_n    = ST_PLACE;
          fetch_n = is_fetch_op;
        end
      end
      ST_PLACE: begin
        if (in_fire) st_n = ST_EXTENT;
      end
      ST_EXTENT: begin
        if (in_fire) begin
          st_n     = fetch_q ? ST_FETCH : ST_STORE;
          img_n    = fetch_q;
          halves_n = 2'd0;
          pend_n   = 1'b0;
          havelo_n = 1'b0;
          oval_n   = 1'b0;
        end
      end
      ST_STORE: begin
        if (in_fire) begin
          halves_n = 2'd2;
        end else if (wr_pix) begin
          if (w_last) begin
            st_n     = ST_IDLE;
            halves_n = 2'd0;
            dv_n     = 1'b1;
          end else begin
            halves_n = halves_q - 2'd1;
          end
        end
      end
      ST_FETCH: begin
        if (rd_abort) begin
          st_n     = ST_PLACE;
          fetch_n  = is_fetch_op;
          img_n    = 1'b0;
          oval_n   = 1'b0;
          pend_n   = 1'b0;
          havelo_n = 1'b0;
        end else begin
          if (rd_issue) begin
            pend_n  = 1'b1;
            plast_n = w_last;
          end
          if (pend_q) begin
            pend_n = 1'b0;
            if (havelo_q || plast_q) begin
              oval_n   = 1'b1;
              havelo_n = 1'b0;
            end else begin
              havelo_n = 1'b1;
            end
          end
          if (out_fire) begin
            oval_n = 1'b0;
            if (!w_active && !pend_q) begin
              st_n  = ST_IDLE;
              img_n = 1'b0;
            end
          end
        end
      end
      default: st_n = ST_IDLE;
    endcase
  end

  always_comb begin
    wbuf_n = in_fire ? in_data : (wbuf_q >> PIX_W);
    out_n  = havelo_q ? {mem_rdata, lo_q} : {{PIX_W{1'b0}}, mem_rdata};
  end

  // ---------------------------------------------------------------- registers
  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      st_q     <= ST_IDLE;
      fetch_q  <= 1'b0;
      halves_q <= 2'd0;
      img_q    <= 1'b0;
      pend_q   <= 1'b0;
      plast_q  <= 1'b0;
      havelo_q <= 1'b0;
      oval_q   <= 1'b0;
      dv_q     <= 1'b0;
    end else begin
      st_q     <= st_n;
      fetch_q  <= fetch_n;
      halves_q <= halves_n;
      img_q    <= img_n;
      pend_q   <= pend_n;
      plast_q  <= plast_n;
      havelo_q <= havelo_n;
      oval_q   <= oval_n;
      dv_q     <= dv_n;
    end
  end

  // data registers with explicit enables, no reset
  logic place_en, wbuf_en, cap_en, dirty_en;
  assign place_en = (st_q == ST_PLACE) && in_fire;
  assign wbuf_en  = (st_q == ST_STORE) && (in_fire || wr_pix);
  assign cap_en   = (st_q == ST_FETCH) && pend_q && !rd_abort;
  assign dirty_en = hdr_done && !fetch_q;

  always_ff @(posedge clk) begin
    if (place_en) begin
      x_q <= in_data[X_BITS-1:0];
      y_q <= in_data[V_LSB +: Y_BITS];
    end
    if (wbuf_en) wbuf_q <= wbuf_n;
    if (cap_en && !havelo_q) lo_q <= mem_rdata;
    if (cap_en && (havelo_q || plast_q)) out_q <= out_n;
    if (dirty_en) begin
      dx_q <= x_q;
      dy_q <= y_q;
      dw_q <= span_w;
      dh_q <= span_h;
    end
  end

  // ---------------------------------------------------------------- outputs
  assign mem_en      = wr_pix || rd_issue;
  assign mem_we      = wr_pix;
  assign mem_addr    = w_addr;
  assign mem_wdata   = wbuf_q[PIX_W-1:0];
  assign out_valid   = oval_q;
  assign out_data    = out_q;
  assign busy        = (st_q != ST_IDLE);
  assign img_ready   = img_q;
  assign dirty_valid = dv_q;
  assign dirty_x     = dx_q;
  assign dirty_y     = dy_q;
  assign dirty_w     = dw_q;
  assign dirty_h     = dh_q;

  // ---------------------------------------------------------------- checks
  // R8: a stalled output word is held unless a new opcode ends the read
  a_r8_hold_word: assert property (@(posedge clk) disable iff (!rst_q)
    (out_valid && !out_ready && !rd_abort) |=> (out_valid && $stable(out_data)));

  // R9: the completion report is a single-cycle pulse
  a_r9_dirty_pulse: assert property (@(posedge clk) disable iff (!rst_q)
    dirty_valid |=> !dirty_valid);

  // R7: an open read always counts as busy
  a_r7_img_busy: assert property (@(posedge clk) disable iff (!rst_q)
    img_ready |-> busy);

  // R2: an idle block leaves the memory alone
  a_r2_idle_quiet: assert property (@(posedge clk) disable iff (!rst_q)
    !busy |-> !mem_en);

  // R4: memory writes never happen while a read is open
  a_r4_no_write_in_read: assert property (@(posedge clk) disable iff (!rst_q)
    (mem_en && mem_we) |-> !img_ready);

  // R10: a new opcode during a read closes it in the next cycle
  a_r10_abort_closes: assert property (@(posedge clk) disable iff (!rst_q)
    rd_abort |=> (!img_ready && !out_valid && busy));
endmodule

// File: tb/rect_xfer_engine_tb.sv
`timescale 1ns/1ps
module rect_xfer_engine_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid, in_ready;
  logic [31:0] in_data;
  logic        out_valid, out_ready;
  logic [31:0] out_data;
  logic        mem_en, mem_we;
  logic [18:0] mem_addr;
  logic [15:0] mem_wdata, mem_rdata;
  logic        busy, img_ready, dirty_valid;
  logic [9:0]  dirty_x;
  logic [8:0]  dirty_y;
  logic [10:0] dirty_w;
  logic [9:0]  dirty_h;

  always #2.5 clk = ~clk;

  rect_xfer_engine u_dut (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .busy(busy), .img_ready(img_ready), .dirty_valid(dirty_valid),
    .dirty_x(dirty_x), .dirty_y(dirty_y), .dirty_w(dirty_w), .dirty_h(dirty_h)
  );

  int total = 0;
  int bad   = 0;

  // ---------------------------------------------------------------- models
  logic [15:0] vmem    [int];
  logic [15:0] ref_mem [int];

  function automatic logic [15:0] bg(int a);
    return 16'((a * 40503) ^ 32'h5a3c);
  endfunction

  function automatic logic [15:0] ref_rd(int a);
    if (ref_mem.exists(a)) return ref_mem[a];
    return bg(a);
  endfunction

  function automatic int span(int f, int bits);
    return (f == 0) ? (1 << bits) : f;
  endfunction

  function automatic int pix_addr(int x, int y, int w, int k);
    return (((y + k / w) % 512) * 1024) + ((x + k % w) % 1024);
  endfunction

  always @(posedge clk) begin
    if (mem_en) begin
      if (mem_we) vmem[int'(mem_addr)] = mem_wdata;
      else mem_rdata <= vmem.exists(int'(mem_addr)) ? vmem[int'(mem_addr)] : bg(int'(mem_addr));
    end
  end

  int wr_cnt = 0, acc_cnt = 0, dcnt = 0;
  logic [39:0] dgot;
  always @(negedge clk) begin
    if (mem_en) acc_cnt++;
    if (mem_en && mem_we) wr_cnt++;
    if (dirty_valid) begin
      dcnt++;
      dgot = {dirty_x, dirty_y, dirty_w, dirty_h};
    end
  end

  // ---------------------------------------------------------------- helpers
  task automatic chk(input bit ok, input string what, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", what, act, exp);
    end
  endtask

  task automatic send_word(input logic [31:0] d, input int gap);
    int g = (gap > 0) ? int'($urandom_range(gap, 0)) : 0;
    repeat (g) @(negedge clk);
    in_data  = d;
    in_valid = 1'b1;
    while (!in_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  function automatic logic [31:0] place_w(int x, int y);
    return (32'(y) << 16) | 32'(x);
  endfunction

  task automatic do_write(input int x, input int y, input int wf, input int hf,
                          input int gap, input bit skip_cmd);
    int w = span(wf, 10);
    int h = span(hf, 9);
    int n = w * h;
    int wc0 = wr_cnt;
    int dc0 = dcnt;
    int mism = 0;
    logic [15:0] px[$];
    logic [39:0] dexp;
    if (!skip_cmd) send_word(32'hA000_0000, gap);
    send_word(place_w(x, y), gap);
    send_word(place_w(wf, hf), gap);
    for (int k = 0; k < n; k++) begin
      px.push_back(16'($urandom));
      ref_mem[pix_addr(x, y, w, k)] = px[k];
    end
    for (int i = 0; i < (n + 1) / 2; i++) begin
      logic [15:0] hi = (2 * i + 1 < n) ? px[2 * i + 1] : 16'($urandom);
      send_word({hi, px[2 * i]}, gap);
    end
    repeat (4) @(negedge clk);
    dexp = {10'(x), 9'(y), 11'(w), 10'(h)};
    chk(dcnt == dc0 + 1 && dgot == dexp, "R9 R3 dirty report", longint'(dgot), longint'(dexp));
    chk(wr_cnt - wc0 == n, "R5 write count", wr_cnt - wc0, n);
    for (int k = 0; k < n; k++) begin
      int a = pix_addr(x, y, w, k);
      if (!vmem.exists(a) || vmem[a] != px[k]) mism++;
    end
    chk(mism == 0, "R4 R6 written pixels mismatching", mism, 0);
    chk(!busy, "R2 idle after write", busy, 0);
  endtask

  task automatic do_read(input int x, input int y, input int wf, input int hf, input int pct);
    int w = span(wf, 10);
    int h = span(hf, 9);
    int n = w * h;
    int nw = (n + 1) / 2;
    int mism = 0;
    logic [31:0] exp_q[$];
    logic [31:0] got_q[$];
    for (int i = 0; i < nw; i++) begin
      logic [15:0] lo = ref_rd(pix_addr(x, y, w, 2 * i));
      logic [15:0] hi = (2 * i + 1 < n) ? ref_rd(pix_addr(x, y, w, 2 * i + 1)) : 16'h0;
      exp_q.push_back({hi, lo});
    end
    fork
      begin
        send_word(32'hC000_0000, 1);
        send_word(place_w(x, y), 1);
        send_word(place_w(wf, hf), 1);
        chk(img_ready == 1'b1, "R7 img_ready raised", img_ready, 1);
      end
      begin
        int got = 0;
        while (got < nw) begin
          @(negedge clk);
          out_ready = ($urandom % 100) < pct;
          if (out_valid && out_ready) begin
            got_q.push_back(out_data);
            got++;
          end
        end
        @(negedge clk);
        out_ready = 1'b0;
      end
    join
    repeat (3) @(negedge clk);
    chk(!img_ready && !busy, "R7 read closed", {img_ready, busy}, 0);
    for (int i = 0; i < nw; i++)
      if (got_q[i] != exp_q[i]) begin
        if (mism == 0)
          $display("  word %0d act=%08h exp=%08h", i, got_q[i], exp_q[i]);
        mism++;
      end
    chk(mism == 0, "R8 R4 R5 read words mismatching", mism, 0);
  endtask

  task automatic finish_run;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  // ---------------------------------------------------------------- watchdog
  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog expired act=hung exp=done");
    finish_run();
  end

  // ---------------------------------------------------------------- main
  initial begin
    int a0, w0;
    void'($urandom(32'd7211));
    in_valid  = 1'b0;
    in_data   = '0;
    out_ready = 1'b0;
    rst_n     = 1'b0;
    repeat (4) @(negedge clk);
    // R1
    chk(!busy && !img_ready && !out_valid && !dirty_valid && !mem_en, "R1 reset outputs",
        {busy, img_ready, out_valid, dirty_valid, mem_en}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(in_ready == 1'b1, "R1 idle ready", in_ready, 1);

    // R2: foreign opcode and stray data dropped
    a0 = acc_cnt;
    send_word(32'h2800_0000, 0);
    send_word(32'h0001_1234, 0);
    send_word(32'hE100_0000, 0);
    @(negedge clk);
    chk(!busy && acc_cnt == a0 && !out_valid, "R2 foreign words ignored", acc_cnt - a0, 0);

    // R4 R5: odd width straddling row ends at both wrap corners
    do_write(1022, 511, 3, 2, 2, 1'b0);
    do_read(1022, 511, 3, 2, 40);
    // R6: back-to-back words, then long gaps
    do_write(10, 20, 5, 1, 0, 1'b0);
    do_write(11, 21, 7, 3, 6, 1'b0);
    do_read(10, 20, 9, 3, 100);

    // R3: zero width field is 1024, zero height field is 512
    do_write(5, 3, 0, 1, 0, 1'b0);
    do_read(1020, 3, 8, 1, 70);
    do_read(7, 200, 1, 0, 90);

    // R10: read cut off by a write opcode with a word staged
    out_ready = 1'b0;
    send_word(32'hC000_0000, 0);
    send_word(place_w(100, 5), 0);
    send_word(place_w(4, 4), 0);
    repeat (8) @(negedge clk);
    chk(out_valid == 1'b1, "R8 stalled word offered", out_valid, 1);
    w0 = wr_cnt;
    send_word(32'hA000_0000, 0);
    chk(!img_ready && !out_valid && busy, "R10 read ended by new opcode",
        {img_ready, out_valid, busy}, 3'b001);
    do_write(200, 7, 3, 2, 1, 1'b1);
    chk(!out_valid && wr_cnt - w0 == 6, "R10 staged word dropped, write intact",
        {out_valid, 8'(wr_cnt - w0)}, 6);

    // random mix
    for (int i = 0; i < 12; i++) begin
      int rx  = $urandom % 1024;
      int ry  = $urandom % 512;
      int rwf = 1 + $urandom % 9;
      int rhf = 1 + $urandom % 5;
      do_write(rx, ry, rwf, rhf, $urandom % 4, 1'b0);
      do_read(rx, ry, rwf, rhf, 30 + $urandom % 71);
    end

    finish_run();
  end
endmodule